// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Zero and Overflow Status

This block is the purely combinational compute stage of a small accumulator machine. Each cycle it takes the current accumulator value, an 8-bit operand fetched by direct addressing, and a 5-bit operation select. From these it forms an 8-bit result, a zero indication and a signed overflow indication. The surrounding control logic writes the result back to the accumulator and latches the two indications into flag registers. Those flags later steer the branch-on-zero and branch-on-overflow instructions.

Subtraction, increment, decrement and negation all run through one shared adder. Each gets there by inverting an input and setting the carry-in. Shifts move the accumulator by one bit position. There are no registers inside the block, so there is no back-pressure or handshake. Results follow the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: Select value 0 (PASS) drives the result with the operand unchanged, and overflow is 0.
- R2: Select 1 (ADD) gives accumulator plus operand, and select 2 (SUB) gives accumulator minus operand, both modulo 256.
- R3: For ADD and SUB, overflow is 1 exactly when the true signed (two's-complement) result lies outside -128..127.
- R4: Select 3 (INC) gives accumulator plus one and select 4 (DEC) gives accumulator minus one. Overflow is 1 only for INC of 0x7F and DEC of 0x80.
- R5: Select 5 (NEG) gives the two's-complement negative of the accumulator. Negating 0x80 gives 0x80 with overflow 1, and every other value gives overflow 0.
- R6: Select 6 (AND), 7 (OR) and 8 (XOR) combine accumulator and operand bit by bit, with overflow 0.
- R7: Select 9 (logical left) shifts the accumulator left one bit and puts 0 into bit 0. Select 10 (logical right) shifts it right one bit and puts 0 into bit 7. Overflow is 0 for both.
- R8: Select 11 (arithmetic left) shifts the accumulator left one bit and puts 0 into bit 0, with overflow 1 when bit 7 changes. Select 12 (arithmetic right) copies the old bit 7 into the new bit 7, with overflow 0.
- R9: For selects 0 to 12, zero is 1 exactly when the 8-bit result equals 0x00.
- R10: Selects 13 to 31 are unused. For these, the result equals the accumulator, and zero and overflow are both 0, even when the accumulator is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Operand from memory or the instruction |
| op_i | input | 5 | Operation select, encodings as in R1 to R10 |
| result_o | output | 8 | Computed result for write-back |
| zero_o | output | 1 | Result-is-zero indication |
| ovf_o | output | 1 | Signed overflow indication |

## Verification
All three outputs are combinational, so each one is due in the same cycle its inputs are applied, with no register in between. The bench applies a new vector just after a rising clock edge and compares result, zero and overflow at the next falling edge, half a period later, when the outputs have settled. Every select value from 0 to 31 is crossed with sign-boundary accumulator and operand values, including 0x7F, 0x80 and 0xFF. A run of random vectors follows.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_NEG  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_SHL  = 5'd9,
    OP_SHR  = 5'd10,
    OP_SAL  = 5'd11,
    OP_SAR  = 5'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  assign sum_o = x_i + y_i + {{(W-1){1'b0}}, cin_i};
  // signed overflow: like-signed inputs producing an opposite-signed sum
  assign ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  input  logic         arith_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  always_comb begin
    if (left_i) begin
      res_o = {a_i[MSB-1:0], 1'b0};
      ovf_o = arith_i & (a_i[MSB] ^ a_i[MSB-1]);
    end else begin
      res_o = {arith_i & a_i[MSB], a_i[MSB:1]};
      ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    acc_i,
  input  logic [W-1:0]    opnd_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            ovf_o
);
  localparam logic [W-1:0] ALL0 = '0;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] add_x, add_y, add_sum, sh_res, lg_res;
  logic         add_cin, add_ovf, sh_left, sh_arith, sh_ovf, sel_ok;
  logic_fn_e    lg_fn;

  // steer the single adder: subtract, step and negate via inversion + carry-in
  always_comb begin
    add_x   = acc_i;
    add_y   = opnd_i;
    add_cin = 1'b0;
    case (op_i)
      OP_SUB: begin add_y = ~opnd_i; add_cin = 1'b1; end
      OP_INC: begin add_y = ALL0;    add_cin = 1'b1; end
      OP_DEC: begin add_y = ALL1;                    end
      OP_NEG: begin add_x = ~acc_i; add_y = ALL0; add_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_add (
    .x_i(add_x), .y_i(add_y), .cin_i(add_cin), .sum_o(add_sum), .ovf_o(add_ovf)
  );

  assign sh_left  = (op_i == OP_SHL) || (op_i == OP_SAL);
  assign sh_arith = (op_i == OP_SAL) || (op_i == OP_SAR);

  alu_shift #(.W(W)) u_shift (
    .a_i(acc_i), .left_i(sh_left), .arith_i(sh_arith), .res_o(sh_res), .ovf_o(sh_ovf)
  );

  always_comb begin
    case (op_i)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      default: lg_fn = LG_AND;
    endcase
  end

  alu_logic #(.W(W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .fn_i(lg_fn), .res_o(lg_res)
  );

  always_comb begin
    sel_ok   = 1'b1;
    result_o = acc_i;
    ovf_o    = 1'b0;
    case (op_i)
      OP_PASS:                               result_o = opnd_i;
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: begin result_o = add_sum; ovf_o = add_ovf; end
      OP_AND, OP_OR, OP_XOR:                 result_o = lg_res;
      OP_SHL, OP_SHR, OP_SAL, OP_SAR:        begin result_o = sh_res; ovf_o = sh_ovf; end
      default:                               sel_ok = 1'b0;
    endcase
  end

  assign zero_o = sel_ok && (result_o == ALL0);
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]    acc_i,
  input logic [W-1:0]    opnd_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    result_o,
  input logic            zero_o,
  input logic            ovf_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!$isunknown({acc_i, opnd_i, op_i})) begin
      if (op_i <= OP_SAR) begin
        assert_zero_flag_R9: assert (zero_o == (result_o == '0))
          else $error("zero flag disagrees with result");
      end else begin
        assert_unused_sel_R10: assert (result_o == acc_i && !zero_o && !ovf_o)
          else $error("unused select altered outputs");
      end
      if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
        assert_logic_no_ovf_R6: assert (!ovf_o) else $error("logic op raised overflow");
      end
      if (op_i == OP_PASS) begin
        assert_pass_R1: assert (result_o == opnd_i && !ovf_o) else $error("pass-through wrong");
      end
      if (op_i == OP_ADD && ovf_o) begin
        assert_add_ovf_R3: assert (acc_i[W-1] == opnd_i[W-1] && result_o[W-1] != acc_i[W-1])
          else $error("add overflow without sign clash");
      end
      if (op_i == OP_INC) begin
        assert_inc_ovf_R4: assert (ovf_o == (acc_i == MAX_POS)) else $error("inc overflow wrong");
      end
      if (op_i == OP_NEG && acc_i == MIN_NEG) begin
        assert_neg_min_R5: assert (result_o == MIN_NEG && ovf_o) else $error("negate of min wrong");
      end
      if (op_i == OP_SAR) begin
        assert_sar_sign_R8: assert (result_o[W-1] == acc_i[W-1] && !ovf_o)
          else $error("arith right shift lost sign");
      end
    end
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc, opnd, res;
  logic [4:0] op;
  logic       zf, vf;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core uut (
    .acc_i(acc), .opnd_i(opnd), .op_i(op),
    .result_o(res), .zero_o(zf), .ovf_o(vf)
  );

  function automatic string req_of(int o);
    case (o)
      0: return "R1";  1, 2: return "R2/R3";  3, 4: return "R4";  5: return "R5";
      6, 7, 8: return "R6";  9, 10: return "R7";  11, 12: return "R8";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference: returns {zero, ovf, result}
  function automatic logic [9:0] model(int o, int a, int b);
    int sa, sb, t, r;
    bit v;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    v = 0;
    case (o)
      0:  r = b;
      1:  begin t = sa + sb; r = (a + b) & 255;   v = (t > 127 || t < -128); end
      2:  begin t = sa - sb; r = (a - b) & 255;   v = (t > 127 || t < -128); end
      3:  begin t = sa + 1;  r = (a + 1) & 255;   v = (t > 127); end
      4:  begin t = sa - 1;  r = (a + 255) & 255; v = (t < -128); end
      5:  begin t = -sa;     r = (256 - a) & 255; v = (t > 127); end
      6:  r = a & b;
      7:  r = a | b;
      8:  r = a ^ b;
      9:  r = (a * 2) & 255;
      10: r = a / 2;
      11: begin t = sa * 2; r = (a * 2) & 255; v = (t > 127 || t < -128); end
      12: r = a / 2 + ((a >= 128) ? 128 : 0);
      default: return {1'b0, 1'b0, 8'(a)};
    endcase
    return {(r == 0), v, 8'(r)};
  endfunction

  task automatic apply(int o, int a, int b);
    logic [9:0] exp;
    @(posedge clk);
    #0.5;
    op = 5'(o); acc = 8'(a); opnd = 8'(b);
    exp = model(o, a, b);
    @(negedge clk);
    n_vec++;
    if (res !== exp[7:0]) begin
      n_bad++;
      $display("FAIL %s result op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               req_of(o), o, a, b, res, exp[7:0]);
    end
    if (vf !== exp[8]) begin
      n_bad++;
      $display("FAIL %s overflow op=%0d a=%02h b=%02h actual=%0b expected=%0b",
               (o > 12) ? "R10" : req_of(o), o, a, b, vf, exp[8]);
    end
    if (zf !== exp[9]) begin
      n_bad++;
      $display("FAIL %s zero op=%0d a=%02h b=%02h actual=%0b expected=%0b",
               (o > 12) ? "R10" : "R9", o, a, b, zf, exp[9]);
    end
  endtask

  int corner[10] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h40, 8'h55, 8'hAA};

  initial begin
    op = '0; acc = '0; opnd = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // first vector: idle pass of zero must report zero (R1, R9)
    apply(0, 0, 0);
    // named boundary cases
    apply(3, 8'h7F, 0);     // R4 inc overflow
    apply(4, 8'h80, 0);     // R4 dec overflow
    apply(5, 8'h80, 0);     // R5 negate min
    apply(1, 8'h7F, 8'h01); // R3 add overflow
    apply(2, 8'h80, 8'h01); // R3 sub overflow
    apply(11, 8'h40, 0);    // R8 arith left overflow
    apply(12, 8'h81, 0);    // R8 sign copy
    apply(10, 8'h81, 0);    // R7 zero fill
    apply(13, 8'h00, 8'h12); // R10 zero flag stays 0
    apply(31, 8'h5A, 8'hFF); // R10
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply(o, corner[i], corner[j]);
    for (int k = 0; k < 1500; k++)
      apply(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule